// File: doc/BRIEF.md
# Multi-Bank Memory Chip-Select Decoder

This block sits between the bus and the memory timing engines. It checks every bus access against eight programmable memory banks and drives one chip-select for the bank that serves the access. The same cycle's result also reports which timing engine handles the access and whether that bank wants parity.

Each bank holds a base address, a power-of-two size, a read-only bit, an access-type code with a compare mask, a parity-enable bit, a machine-select code and a valid bit. An access is refused when its type does not fit the selected bank, or when it is a write to a read-only bank. In both cases no chip-select is driven and an error flag is raised instead. Accesses from an external master carry a narrower address, which the block widens with zeros in the top bits. Banks are programmed through a register-write port that takes a bank index, a field code and data.

Top module: `memsel_top`

## Requirements
- R1: After reset every bank is invalid, so all outputs read zero, and any access reports only no-match.
- R2: Results are registered and appear exactly one clock after the cycle with `acc_valid` high. A cycle without `acc_valid` leaves every output zero in the following cycle.
- R3: A valid bank hits when the access address equals its base on every bit at or above position 15+n, where n is the bank's size code (bank size is 2^(15+n) bytes). Size codes above 11 act as 11 (64 MB).
- R4: With `acc_ext` high, only address bits 25:0 are used, and bits 31:26 are taken as zero before the compare.
- R5: When several banks hit, the lowest-numbered one is selected, and `cs` stays one-hot or zero.
- R6: A write (`acc_write`=1) whose selected bank is read-only drives no chip-select and raises `wp_err`. A read of the same bank asserts its chip-select.
- R7: The selected bank refuses an access whose type differs from its type code on any bit where its compare mask is 1. In that case `type_err` is raised, no chip-select is driven, and `wp_err` stays low even for a write to a read-only bank.
- R8: With a chip-select asserted, `ms` carries the selected bank's machine-select code and `par_en` its parity bit. Both are zero otherwise.
- R9: An access that hits no bank raises `no_match` for one cycle and drives no chip-select and no error.
- R10: Register-write port fields (`cfg_field`) are as follows. Field 0 is the base (`cfg_data[31:0]`). Field 1 is the size code (`cfg_data[3:0]`). Field 2 holds the attributes: bit 0 valid, bit 1 read-only, bit 2 parity, bits 5:4 machine-select. Field 3 holds the type code in bits 3:0 and the compare mask in bits 11:8. A write takes effect from the next cycle on, so an access in the same cycle is decoded with the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_ext | input | 1 | Access comes from an external master (narrow address) |
| acc_addr | input | 32 | Access address |
| acc_type | input | 4 | Access-type code |
| cfg_we | input | 1 | Configuration write enable |
| cfg_bank | input | 3 | Bank index for configuration write |
| cfg_field | input | 2 | Field code for configuration write |
| cfg_data | input | 32 | Configuration write data |
| cs | output | 8 | One-hot chip-select |
| ms | output | 2 | Machine-select code of the selected bank |
| par_en | output | 1 | Parity enable of the selected bank |
| wp_err | output | 1 | Write to a read-only bank |
| type_err | output | 1 | Access type refused by the selected bank |
| no_match | output | 1 | No bank hit |

## Verification
A configuration write and an access decode can land in the same clock, and the access must then be decoded with the settings that were in place before the write. The bench provokes this in two ways. A directed case clears a bank's valid bit in the very cycle an access targets that bank. Random stimulus also issues configuration writes alongside accesses. Its reference model computes the expected result before it applies the write, so a decode that uses the new settings too early shows up as a mismatch on `cs` or on the error flags.

// File: rtl/memsel_pkg.sv
package memsel_pkg;
  localparam int FIELD_W = 2;
  localparam int MS_W    = 2;

  typedef enum logic [FIELD_W-1:0] {
    FLD_BASE = 2'd0,
    FLD_SIZE = 2'd1,
    FLD_ATTR = 2'd2,
    FLD_TYPE = 2'd3
  } cfg_field_e;

  localparam int ATTR_VALID_BIT = 0;
  localparam int ATTR_RO_BIT    = 1;
  localparam int ATTR_PAR_BIT   = 2;
  localparam int ATTR_MS_LSB    = 4;
  localparam int TYPE_MASK_LSB  = 8;
endpackage

// File: rtl/memsel_cfg.sv
module memsel_cfg
  import memsel_pkg::*;
#(
  parameter int NBANK  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 4,
  parameter int TYPE_W = 4,
  localparam int IDX_W = $clog2(NBANK)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [IDX_W-1:0]    bank,
  input  logic [FIELD_W-1:0]  field,
  input  logic [DATA_W-1:0]   data,
  output logic [ADDR_W-1:0]   base_q  [NBANK],
  output logic [SIZE_W-1:0]   size_q  [NBANK],
  output logic                valid_q [NBANK],
  output logic                ro_q    [NBANK],
  output logic                par_q   [NBANK],
  output logic [MS_W-1:0]     ms_q    [NBANK],
  output logic [TYPE_W-1:0]   tcode_q [NBANK],
  output logic [TYPE_W-1:0]   tmask_q [NBANK]
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic sel;
    assign sel = we && (bank == IDX_W'(b));
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[b]  <= '0;
        size_q[b]  <= '0;
        valid_q[b] <= 1'b0;
        ro_q[b]    <= 1'b0;
        par_q[b]   <= 1'b0;
        ms_q[b]    <= '0;
        tcode_q[b] <= '0;
        tmask_q[b] <= '0;
      end else if (sel) begin
        case (cfg_field_e'(field))
          FLD_BASE: base_q[b] <= data[ADDR_W-1:0];
          FLD_SIZE: size_q[b] <= data[SIZE_W-1:0];
          FLD_ATTR: begin
            valid_q[b] <= data[ATTR_VALID_BIT];
            ro_q[b]    <= data[ATTR_RO_BIT];
            par_q[b]   <= data[ATTR_PAR_BIT];
            ms_q[b]    <= data[ATTR_MS_LSB +: MS_W];
          end
          FLD_TYPE: begin
            tcode_q[b] <= data[0 +: TYPE_W];
            tmask_q[b] <= data[TYPE_MASK_LSB +: TYPE_W];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/memsel_bank_match.sv
module memsel_bank_match #(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 4,
  parameter int TYPE_W    = 4,
  parameter int MIN_SHIFT = 15,
  parameter int MAX_CODE  = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [TYPE_W-1:0] atype,
  input  logic [ADDR_W-1:0] base,
  input  logic [SIZE_W-1:0] size,
  input  logic              valid,
  input  logic [TYPE_W-1:0] tcode,
  input  logic [TYPE_W-1:0] tmask,
  output logic              addr_hit,
  output logic              type_ok
);
  logic [SIZE_W-1:0] code_c;
  logic [ADDR_W-1:0] keep;

  always_comb begin
    code_c   = (size > SIZE_W'(MAX_CODE)) ? SIZE_W'(MAX_CODE) : size;
    keep     = {ADDR_W{1'b1}} << (MIN_SHIFT + int'(code_c));
    addr_hit = valid && (((addr ^ base) & keep) == '0);
    type_ok  = (((atype ^ tcode) & tmask) == '0);
  end
endmodule

// File: rtl/memsel_select.sv
module memsel_select
  import memsel_pkg::*;
#(
  parameter int NBANK = 8,
  localparam int IDX_W = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic             hit   [NBANK],
  input  logic             tok   [NBANK],
  input  logic             ro    [NBANK],
  input  logic             par   [NBANK],
  input  logic [MS_W-1:0]  msel  [NBANK],
  output logic [NBANK-1:0] cs,
  output logic [MS_W-1:0]  ms,
  output logic             par_en,
  output logic             wp_err,
  output logic             type_err,
  output logic             no_match
);
  logic             found;
  logic [IDX_W-1:0] win;
  logic             grant, wp_d, te_d, nm_d;

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found = 1'b1;
        win   = IDX_W'(i);
      end
    end
    te_d  = acc_valid && found && !tok[win];
    wp_d  = acc_valid && found && tok[win] && acc_write && ro[win];
    grant = acc_valid && found && !te_d && !wp_d;
    nm_d  = acc_valid && !found;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs       <= '0;
      ms       <= '0;
      par_en   <= 1'b0;
      wp_err   <= 1'b0;
      type_err <= 1'b0;
      no_match <= 1'b0;
    end else begin
      cs       <= grant ? (NBANK'(1) << win) : '0;
      ms       <= grant ? msel[win] : '0;
      par_en   <= grant && par[win];
      wp_err   <= wp_d;
      type_err <= te_d;
      no_match <= nm_d;
    end
  end

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(acc_valid) |-> (cs == '0 && !no_match && !wp_err && !type_err)); // R2
  AST_WP_NO_CS: assert property (@(posedge clk) disable iff (rst)
    wp_err |-> (cs == '0 && !type_err)); // R6
  AST_TYPE_NO_CS: assert property (@(posedge clk) disable iff (rst)
    type_err |-> (cs == '0)); // R7
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $countones({|cs, wp_err, type_err, no_match}) <= 1); // R9
  AST_PAR_WITH_CS: assert property (@(posedge clk) disable iff (rst)
    (par_en || ms != '0) |-> (cs != '0)); // R8
endmodule

// File: rtl/memsel_top.sv
module memsel_top
  import memsel_pkg::*;
#(
  parameter int NBANK     = 8,
  parameter int ADDR_W    = 32,
  parameter int EXT_W     = 26,
  parameter int DATA_W    = 32,
  parameter int SIZE_W    = 4,
  parameter int TYPE_W    = 4,
  parameter int MIN_SHIFT = 15,
  parameter int MAX_CODE  = 11,
  localparam int IDX_W    = $clog2(NBANK)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic               acc_ext,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [TYPE_W-1:0]  acc_type,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_bank,
  input  logic [FIELD_W-1:0] cfg_field,
  input  logic [DATA_W-1:0]  cfg_data,
  output logic [NBANK-1:0]   cs,
  output logic [MS_W-1:0]    ms,
  output logic               par_en,
  output logic               wp_err,
  output logic               type_err,
  output logic               no_match
);
  logic [ADDR_W-1:0] base_q  [NBANK];
  logic [SIZE_W-1:0] size_q  [NBANK];
  logic              valid_q [NBANK];
  logic              ro_q    [NBANK];
  logic              par_q   [NBANK];
  logic [MS_W-1:0]   ms_q    [NBANK];
  logic [TYPE_W-1:0] tcode_q [NBANK];
  logic [TYPE_W-1:0] tmask_q [NBANK];
  logic              hit     [NBANK];
  logic              tok     [NBANK];
  logic [ADDR_W-1:0] eff_addr;

  assign eff_addr = acc_ext ? {{(ADDR_W-EXT_W){1'b0}}, acc_addr[EXT_W-1:0]} : acc_addr;

  memsel_cfg #(
    .NBANK(NBANK), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SIZE_W(SIZE_W), .TYPE_W(TYPE_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .bank(cfg_bank), .field(cfg_field),
    .data(cfg_data), .base_q(base_q), .size_q(size_q), .valid_q(valid_q),
    .ro_q(ro_q), .par_q(par_q), .ms_q(ms_q), .tcode_q(tcode_q), .tmask_q(tmask_q)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_match
    memsel_bank_match #(
      .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .TYPE_W(TYPE_W),
      .MIN_SHIFT(MIN_SHIFT), .MAX_CODE(MAX_CODE)
    ) u_match (
      .addr(eff_addr), .atype(acc_type), .base(base_q[b]), .size(size_q[b]),
      .valid(valid_q[b]), .tcode(tcode_q[b]), .tmask(tmask_q[b]),
      .addr_hit(hit[b]), .type_ok(tok[b])
    );
  end

  memsel_select #(.NBANK(NBANK)) u_sel (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .hit(hit), .tok(tok), .ro(ro_q), .par(par_q), .msel(ms_q),
    .cs(cs), .ms(ms), .par_en(par_en), .wp_err(wp_err),
    .type_err(type_err), .no_match(no_match)
  );

  AST_EXT_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_ext) |-> (eff_addr[ADDR_W-1:EXT_W] == '0)); // R4
  AST_NM_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (rst)
    no_match |-> $past(acc_valid)); // R9
endmodule

// File: tb/memsel_top_bench.sv
module memsel_top_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        acc_valid, acc_write, acc_ext;
  logic [31:0] acc_addr;
  logic [3:0]  acc_type;
  logic        cfg_we;
  logic [2:0]  cfg_bank;
  logic [1:0]  cfg_field;
  logic [31:0] cfg_data;
  logic [7:0]  cs;
  logic [1:0]  ms;
  logic        par_en, wp_err, type_err, no_match;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_base  [8];
  logic [3:0]  m_size  [8];
  logic        m_valid [8];
  logic        m_ro    [8];
  logic        m_par   [8];
  logic [1:0]  m_ms    [8];
  logic [3:0]  m_tc    [8];
  logic [3:0]  m_tm    [8];

  always #5 clk = ~clk;

  memsel_top u_memsel_top (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_ext(acc_ext), .acc_addr(acc_addr), .acc_type(acc_type),
    .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_field(cfg_field), .cfg_data(cfg_data),
    .cs(cs), .ms(ms), .par_en(par_en), .wp_err(wp_err),
    .type_err(type_err), .no_match(no_match)
  );

  // packed result: {cs[7:0], ms[1:0], par, wp, te, nm}
  function automatic logic [13:0] model(input logic v, input logic wr, input logic ext,
                                        input logic [31:0] a, input logic [3:0] t);
    logic [31:0] ea, keep;
    int w;
    int sc;
    ea = ext ? {6'b0, a[25:0]} : a;
    w = -1;
    if (!v) return 14'd0;
    for (int i = 7; i >= 0; i--) begin
      sc = (m_size[i] > 4'd11) ? 11 : int'(m_size[i]);
      keep = 32'hFFFF_FFFF << (15 + sc);
      if (m_valid[i] && (((ea ^ m_base[i]) & keep) == 32'd0)) w = i;
    end
    if (w < 0) return 14'b1;
    if (((t ^ m_tc[w]) & m_tm[w]) != 4'd0) return 14'b10;
    if (wr && m_ro[w]) return 14'b100;
    return {8'(1 << w), m_ms[w], m_par[w], 3'b000};
  endfunction

  task automatic model_cfg(input logic [2:0] b, input logic [1:0] f, input logic [31:0] d);
    case (f)
      2'd0: m_base[b] = d;
      2'd1: m_size[b] = d[3:0];
      2'd2: begin m_valid[b] = d[0]; m_ro[b] = d[1]; m_par[b] = d[2]; m_ms[b] = d[5:4]; end
      default: begin m_tc[b] = d[3:0]; m_tm[b] = d[11:8]; end
    endcase
  endtask

  task automatic step(input logic v, input logic wr, input logic ext,
                      input logic [31:0] a, input logic [3:0] t,
                      input logic cwe, input logic [2:0] cb, input logic [1:0] cf,
                      input logic [31:0] cd, input string tag);
    logic [13:0] exp, act;
    @(negedge clk);
    acc_valid = v; acc_write = wr; acc_ext = ext; acc_addr = a; acc_type = t;
    cfg_we = cwe; cfg_bank = cb; cfg_field = cf; cfg_data = cd;
    exp = model(v, wr, ext, a, t);
    if (cwe) model_cfg(cb, cf, cd);
    @(posedge clk);
    #1;
    act = {cs, ms, par_en, wp_err, type_err, no_match};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h act=%b exp=%b", tag, a, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] b, input logic [1:0] f, input logic [31:0] d);
    step(1'b0, 1'b0, 1'b0, 32'd0, 4'd0, 1'b1, b, f, d, "R2");
  endtask

  task automatic acc(input logic wr, input logic ext, input logic [31:0] a,
                     input logic [3:0] t, input string tag);
    step(1'b1, wr, ext, a, t, 1'b0, 3'd0, 2'd0, 32'd0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] rb;
    logic [31:0] ra;
    int dummy;
    dummy = $urandom(32'h5EED_1234);
    for (int i = 0; i < 8; i++) begin
      m_base[i] = 0; m_size[i] = 0; m_valid[i] = 0; m_ro[i] = 0;
      m_par[i] = 0; m_ms[i] = 0; m_tc[i] = 0; m_tm[i] = 0;
    end
    rst = 1'b1;
    acc_valid = 0; acc_write = 0; acc_ext = 0; acc_addr = 0; acc_type = 0;
    cfg_we = 0; cfg_bank = 0; cfg_field = 0; cfg_data = 0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({cs, ms, par_en, wp_err, type_err, no_match} !== 14'd0) begin
      errors++;
      $display("FAIL R1 reset act=%b exp=0", {cs, ms, par_en, wp_err, type_err, no_match});
    end
    @(negedge clk);
    rst = 1'b0;
    acc(1'b0, 1'b0, 32'h0000_0000, 4'd0, "R1");
    acc(1'b1, 1'b0, 32'hDEAD_BEEF, 4'd7, "R1");

    // bank 3: 32 KB at 0x1000_0000, ms=1, parity on
    cfg(3'd3, 2'd0, 32'h1000_0000);
    cfg(3'd3, 2'd1, 32'd0);
    cfg(3'd3, 2'd2, 32'h15);
    acc(1'b0, 1'b0, 32'h1000_7FFF, 4'd0, "R3");
    acc(1'b0, 1'b0, 32'h1000_8000, 4'd0, "R9");
    step(1'b0, 1'b0, 1'b0, 32'h1000_0000, 4'd0, 1'b0, 3'd0, 2'd0, 32'd0, "R2");

    // bank 5: 64 MB overlapping, ms=2, parity off
    cfg(3'd5, 2'd0, 32'h1000_0000);
    cfg(3'd5, 2'd1, 32'd11);
    cfg(3'd5, 2'd2, 32'h21);
    acc(1'b0, 1'b0, 32'h1000_0100, 4'd0, "R5");
    acc(1'b1, 1'b0, 32'h1300_0000, 4'd0, "R8");
    cfg(3'd5, 2'd1, 32'd15);
    acc(1'b0, 1'b0, 32'h13FF_FFFF, 4'd0, "R3");
    acc(1'b0, 1'b0, 32'h1400_0000, 4'd0, "R3");

    // bank 0: 32 KB at 0x0200_0000 for external master
    cfg(3'd0, 2'd0, 32'h0200_0000);
    cfg(3'd0, 2'd2, 32'h01);
    acc(1'b0, 1'b1, 32'hFE00_0000, 4'd0, "R4");
    acc(1'b0, 1'b0, 32'hFE00_0000, 4'd0, "R4");

    // read-only
    cfg(3'd0, 2'd2, 32'h03);
    acc(1'b1, 1'b0, 32'h0200_0010, 4'd0, "R6");
    acc(1'b0, 1'b0, 32'h0200_0010, 4'd0, "R6");

    // type filter: code 1010, compare bits 3:2
    cfg(3'd0, 2'd3, 32'h0000_0C0A);
    acc(1'b0, 1'b0, 32'h0200_0020, 4'b1001, "R7");
    acc(1'b0, 1'b0, 32'h0200_0020, 4'b0110, "R7");
    acc(1'b1, 1'b0, 32'h0200_0020, 4'b0110, "R7");

    // same-cycle configuration write and access
    step(1'b1, 1'b0, 1'b0, 32'h0200_0020, 4'b1000, 1'b1, 3'd0, 2'd2, 32'h0, "R10");
    acc(1'b0, 1'b0, 32'h0200_0020, 4'b1000, "R10");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      rb = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) begin
        logic [1:0] f;
        logic [31:0] d;
        f = 2'($urandom_range(0, 3));
        d = $urandom;
        if (f == 2'd0 && $urandom_range(0, 1) == 1) d[31:26] = 6'd0;
        if (f == 2'd2 && $urandom_range(0, 3) != 0) d[0] = 1'b1;
        if (f == 2'd3 && $urandom_range(0, 1) == 1) d[11:8] = 4'd0;
        step($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 1'b0,
             m_base[rb] ^ ($urandom & 32'h0000_FFFF), 4'($urandom),
             1'b1, rb, f, d, "R10");
      end else begin
        ra = ($urandom_range(0, 4) == 0) ? $urandom
                                         : m_base[rb] ^ ($urandom & 32'h01FF_FFFF);
        step($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1,
             $urandom_range(0, 5) == 0, ra, 4'($urandom),
             1'b0, 3'd0, 2'd0, 32'd0, "R3");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule